// File: doc/BRIEF.md
# Calendar Time Counter with Alarm

The block keeps the time of day as a day count plus hours, minutes and seconds, behind a small bank of 16-bit registers on a simple word-addressed bus. Software loads the time and an alarm time, sets the run bit in the control register, and from then on each accepted one-second pulse on `tick_1hz` advances the count. The pulse comes from a prescaler outside the block.

Every increment is followed by an evaluation cycle. In that cycle a seconds event is posted, and the alarm is compared with the new time. Each event sets a bit in a status register. Software clears a status bit by writing a 1 to it. The interrupt line combines the status bits with an enable mask. A stopwatch register is present only as readable and writable storage.

The sequencer has three named states. HALT is entered while the run bit is 0. RUN is the idle wait while the run bit is 1. EVAL lasts one cycle and follows every accepted pulse. The transitions are: STEP (any state to EVAL, on an accepted pulse), SETTLE (EVAL or HALT to RUN, when no pulse is accepted and the run bit is 1), STOP (any state to HALT, when no pulse is accepted and the run bit is 0), and IDLE (RUN to RUN).

Top module: `rtc_calendar`

## Requirements
- R1: After reset, every register reads 0 and `irq_out` is low. The registers are time, alarm, control, status, enable, stopwatch and both day registers.
- R2: Register word offsets are decoded from `bus_addr[5:2]`:
  - 0x00 hour/minute, with the hour in bits 12:8 and the minute in bits 5:0.
  - 0x04 seconds, in bits 5:0.
  - 0x08 alarm hour/minute, in the same layout as 0x00.
  - 0x0C alarm seconds.
  - 0x10 control, all 16 bits kept.
  - 0x14 status.
  - 0x18 enable, all 16 bits kept.
  - 0x1C stopwatch, all 16 bits kept.
  - 0x20 day count, in the low DAY_W bits.
  - 0x24 alarm day.
  
  Bits outside these fields, and unmapped offsets, read 0. Reads are combinational.
- R3: A pulse on `tick_1hz` while control bit 7 is 1 advances the seconds at that clock edge. While control bit 7 is 0, pulses are ignored.
- R4: Counting rolls over as follows. A seconds value of 59 or more goes to 0 and carries into the minutes. A minutes value of 59 or more goes to 0 and carries into the hours. An hours value of 23 or more goes to 0 and carries into the day.
- R5: The day count wraps to 0 when it passes 2^DAY_W-1.
- R6: A write to the hour/minute, seconds or day register lands at the next edge. A pulse in that same cycle is discarded, with no increment and no evaluation.
- R7: The clock edge after an accepted pulse sets status bit 4 (the seconds event).
- R8: In that same edge, status bit 2 (the alarm) is set when day, hour, minute and seconds all equal the alarm registers. Loading a time equal to the alarm sets nothing.
- R9: Writing status clears each flag bit (0, 2, 4) written as 1. Bits written as 0 are left unchanged.
- R10: `irq_out` is high exactly when some status bit and the same enable bit are both 1.
- R11: When a flag is set and cleared by a write at the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte offset; bits 5:2 select the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq_out | output | 1 | Interrupt request |

## Verification
A wrong carry or a lost pulse shows up in the seconds or hour/minute read data at the very next edge. The bench compares the read data with its own model on every cycle, so such a fault is visible one cycle after it happens. A sequencer that evaluates in the wrong cycle, or that misses a match, leaves status bits 2 or 4 wrong one edge after the increment. Because the interrupt line combines those bits with the enable mask, such a fault shows on `irq_out` in that same cycle. Faults in the write-1-to-clear logic or in the write-over-pulse priority persist until the register is rewritten, so any later read exposes them.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
    typedef enum logic [1:0] {S_HALT, S_RUN, S_EVAL} cal_state_e;

    localparam logic [3:0] W_HM     = 4'd0;
    localparam logic [3:0] W_SEC    = 4'd1;
    localparam logic [3:0] W_AHM    = 4'd2;
    localparam logic [3:0] W_ASEC   = 4'd3;
    localparam logic [3:0] W_CTRL   = 4'd4;
    localparam logic [3:0] W_STAT   = 4'd5;
    localparam logic [3:0] W_IEN    = 4'd6;
    localparam logic [3:0] W_SWATCH = 4'd7;
    localparam logic [3:0] W_DAY    = 4'd8;
    localparam logic [3:0] W_ADAY   = 4'd9;

    localparam int FLAG_SW    = 0;
    localparam int FLAG_ALARM = 2;
    localparam int FLAG_SEC   = 4;
    localparam int CTRL_RUN   = 7;
endpackage

// File: rtl/rtc_cal_time.sv
module rtc_cal_time #(
    parameter int DAY_W = 16,
    parameter int HR_W  = 5,
    parameter int MN_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             wr_hm,
    input  logic             wr_sec,
    input  logic             wr_day,
    input  logic [15:0]      wdata,
    output logic [HR_W-1:0]  hr_q,
    output logic [MN_W-1:0]  mn_q,
    output logic [MN_W-1:0]  sc_q,
    output logic [DAY_W-1:0] day_q
);
    localparam logic [MN_W-1:0] MN_LAST = MN_W'(59);
    localparam logic [HR_W-1:0] HR_LAST = HR_W'(23);

    logic sc_wrap, mn_wrap, hr_wrap;

    always_comb begin
        sc_wrap = (sc_q >= MN_LAST);
        mn_wrap = sc_wrap && (mn_q >= MN_LAST);
        hr_wrap = mn_wrap && (hr_q >= HR_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hr_q  <= '0;
            mn_q  <= '0;
            sc_q  <= '0;
            day_q <= '0;
        end else begin
            if (wr_hm) begin
                hr_q <= wdata[8 +: HR_W];
                mn_q <= wdata[MN_W-1:0];
            end
            if (wr_sec) sc_q  <= wdata[MN_W-1:0];
            if (wr_day) day_q <= wdata[DAY_W-1:0];
            if (step) begin
                sc_q <= sc_wrap ? '0 : sc_q + 1'b1;
                if (sc_wrap) mn_q <= mn_wrap ? '0 : mn_q + 1'b1;
                if (mn_wrap) hr_q <= hr_wrap ? '0 : hr_q + 1'b1;
                if (hr_wrap) day_q <= day_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_cal_fsm.sv
module rtc_cal_fsm
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       tick,
    input  logic       time_wr,
    output logic       step,
    output logic       eval,
    output cal_state_e state_q
);
    cal_state_e state_d;
    logic       accept;

    assign accept = run_en && tick && !time_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HALT: state_d = accept ? S_EVAL : (run_en ? S_RUN : S_HALT);
            S_RUN:  state_d = accept ? S_EVAL : (run_en ? S_RUN : S_HALT);
            S_EVAL: state_d = accept ? S_EVAL : (run_en ? S_RUN : S_HALT);
            default: state_d = S_HALT;
        endcase
    end

    always_comb begin
        step = accept;
        eval = 1'b0;
        unique case (state_q)
            S_HALT: eval = 1'b0;
            S_RUN:  eval = 1'b0;
            S_EVAL: eval = 1'b1;
            default: eval = 1'b0;
        endcase
    end
endmodule

// File: rtl/rtc_cal_flags.sv
module rtc_cal_flags
    import rtc_cal_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        eval,
    input  logic        match,
    input  logic        wr_stat,
    input  logic        wr_ien,
    input  logic [15:0] wdata,
    output logic [15:0] status_q,
    output logic [15:0] ien_q,
    output logic        irq
);
    localparam int NFLAG = 3;
    localparam int FLAG_POS [NFLAG] = '{FLAG_SW, FLAG_ALARM, FLAG_SEC};

    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] flag_q;

    assign set_v = {eval, eval && match, 1'b0};

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           flag_q[g] <= 1'b0;
            else if (set_v[g])                    flag_q[g] <= 1'b1;
            else if (wr_stat && wdata[FLAG_POS[g]]) flag_q[g] <= 1'b0;
        end
    end

    always_comb begin
        status_q = '0;
        for (int i = 0; i < NFLAG; i++) status_q[FLAG_POS[i]] = flag_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ien_q <= '0;
        else if (wr_ien) ien_q <= wdata;
    end

    assign irq = |(status_q & ien_q);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int DAY_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_1hz,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [5:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        irq_out
);
    localparam int HR_W = 5;
    localparam int MN_W = 6;

    logic [3:0]       word;
    logic [9:0]       wr_hit;
    logic             time_wr, step, eval, match, run_en;
    logic [HR_W-1:0]  t_hr, a_hr;
    logic [MN_W-1:0]  t_mn, t_sec, a_mn, a_sec;
    logic [DAY_W-1:0] t_day, a_day;
    logic [15:0]      ctrl_q, swatch_q, status_q, ien_q;
    cal_state_e       state_q;

    assign word = bus_addr[5:2];

    for (genvar g = 0; g < 10; g++) begin : g_dec
        assign wr_hit[g] = bus_sel && bus_wr && (word == 4'(g));
    end

    assign time_wr = wr_hit[W_HM] || wr_hit[W_SEC] || wr_hit[W_DAY];
    assign run_en  = ctrl_q[CTRL_RUN];

    rtc_cal_time #(.DAY_W(DAY_W), .HR_W(HR_W), .MN_W(MN_W)) u_time (
        .clk(clk), .rst_n(rst_n), .step(step),
        .wr_hm(wr_hit[W_HM]), .wr_sec(wr_hit[W_SEC]), .wr_day(wr_hit[W_DAY]),
        .wdata(bus_wdata),
        .hr_q(t_hr), .mn_q(t_mn), .sc_q(t_sec), .day_q(t_day)
    );

    rtc_cal_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick_1hz),
        .time_wr(time_wr), .step(step), .eval(eval), .state_q(state_q)
    );

    assign match = (t_hr == a_hr) && (t_mn == a_mn) &&
                   (t_sec == a_sec) && (t_day == a_day);

    rtc_cal_flags u_flags (
        .clk(clk), .rst_n(rst_n), .eval(eval), .match(match),
        .wr_stat(wr_hit[W_STAT]), .wr_ien(wr_hit[W_IEN]), .wdata(bus_wdata),
        .status_q(status_q), .ien_q(ien_q), .irq(irq_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_hr     <= '0;
            a_mn     <= '0;
            a_sec    <= '0;
            a_day    <= '0;
            ctrl_q   <= '0;
            swatch_q <= '0;
        end else begin
            if (wr_hit[W_AHM]) begin
                a_hr <= bus_wdata[8 +: HR_W];
                a_mn <= bus_wdata[MN_W-1:0];
            end
            if (wr_hit[W_ASEC])   a_sec    <= bus_wdata[MN_W-1:0];
            if (wr_hit[W_ADAY])   a_day    <= bus_wdata[DAY_W-1:0];
            if (wr_hit[W_CTRL])   ctrl_q   <= bus_wdata;
            if (wr_hit[W_SWATCH]) swatch_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (word)
            W_HM:     bus_rdata = {3'b0, t_hr, 2'b0, t_mn};
            W_SEC:    bus_rdata = {10'b0, t_sec};
            W_AHM:    bus_rdata = {3'b0, a_hr, 2'b0, a_mn};
            W_ASEC:   bus_rdata = {10'b0, a_sec};
            W_CTRL:   bus_rdata = ctrl_q;
            W_STAT:   bus_rdata = status_q;
            W_IEN:    bus_rdata = ien_q;
            W_SWATCH: bus_rdata = swatch_q;
            W_DAY:    bus_rdata = 16'(t_day);
            W_ADAY:   bus_rdata = 16'(a_day);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_cal_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        tick_1hz,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [5:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic        irq_out,
    input logic        run_en,
    input logic [5:0]  sec_q,
    input logic [15:0] status_q,
    input cal_state_e  state_q
);
    logic wr_any, tw, sec_wr, stat_wr;
    assign wr_any  = bus_sel && bus_wr;
    assign sec_wr  = wr_any && (bus_addr[5:2] == W_SEC);
    assign stat_wr = wr_any && (bus_addr[5:2] == W_STAT);
    assign tw      = wr_any && (bus_addr[5:2] == W_HM || bus_addr[5:2] == W_SEC
                                || bus_addr[5:2] == W_DAY);

    assert_frozen_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !sec_wr) |=> $stable(sec_q));

    assert_write_beats_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && run_en && sec_wr) |=> (sec_q == $past(bus_wdata[5:0])));

    assert_eval_after_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && run_en && !tw) |=> (state_q == S_EVAL));

    assert_sec_flag_posted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && run_en && !tw) |=> ##1 status_q[FLAG_SEC]);

    assert_w1c_alarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && bus_wdata[FLAG_ALARM] && state_q != S_EVAL) |=> !status_q[FLAG_ALARM]);

    assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (status_q != 16'h0));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .irq_out(irq_out), .run_en(run_en), .sec_q(t_sec),
    .status_q(status_q), .state_q(state_q)
);

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb_top;
    localparam int DAY_W = 16;
    localparam int DMASK = (1 << DAY_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    int m_hr, m_mn, m_sc, m_day, a_hr, a_mn, a_sc, a_day;
    int m_ctrl, m_stat, m_ien, m_sw;
    bit m_pend;

    always #5 clk = ~clk;

    rtc_calendar #(.DAY_W(DAY_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic int mread(input int a);
        case (a >> 2)
            0: return (m_hr << 8) | m_mn;
            1: return m_sc;
            2: return (a_hr << 8) | a_mn;
            3: return a_sc;
            4: return m_ctrl;
            5: return m_stat;
            6: return m_ien;
            7: return m_sw;
            8: return m_day;
            9: return a_day;
            default: return 0;
        endcase
    endfunction

    // reference model, one update per clock
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hr = 0; m_mn = 0; m_sc = 0; m_day = 0;
            a_hr = 0; a_mn = 0; a_sc = 0; a_day = 0;
            m_ctrl = 0; m_stat = 0; m_ien = 0; m_sw = 0; m_pend = 0;
        end else begin
            bit w, tw, acc, hit;
            int wd, sets, clr, wi;
            w = bus_sel && bus_wr;
            wi = int'(bus_addr) >> 2;
            wd = int'(bus_wdata);
            tw = w && (wi == 0 || wi == 1 || wi == 8);
            hit = (m_hr == a_hr) && (m_mn == a_mn) && (m_sc == a_sc) && (m_day == a_day);
            sets = 0;
            if (m_pend) begin
                sets = 16;
                if (hit) sets = sets | 4;
            end
            clr = (w && wi == 5) ? (wd & 21) : 0;
            acc = m_ctrl[7] && tick_1hz && !tw;
            if (w) begin
                case (wi)
                    0: begin m_hr = (wd >> 8) & 31; m_mn = wd & 63; end
                    1: m_sc = wd & 63;
                    2: begin a_hr = (wd >> 8) & 31; a_mn = wd & 63; end
                    3: a_sc = wd & 63;
                    4: m_ctrl = wd;
                    6: m_ien = wd;
                    7: m_sw = wd;
                    8: m_day = wd & DMASK;
                    9: a_day = wd & DMASK;
                    default: ;
                endcase
            end
            if (acc) begin
                if (m_sc >= 59) begin
                    m_sc = 0;
                    if (m_mn >= 59) begin
                        m_mn = 0;
                        if (m_hr >= 23) begin
                            m_hr = 0;
                            m_day = (m_day + 1) & DMASK;
                        end else m_hr = m_hr + 1;
                    end else m_mn = m_mn + 1;
                end else m_sc = m_sc + 1;
            end
            m_stat = (m_stat & ~clr) | sets;
            m_pend = acc;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R2 cycle read data", int'(bus_rdata), mread(int'(bus_addr)));
            chk("R10 cycle irq", int'(irq_out), ((m_stat & m_ien) != 0) ? 1 : 0);
        end
    end

    task automatic wr(input logic [5:0] a, input logic [15:0] d, input logic tk = 1'b0);
        @(posedge clk); #3;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; tick_1hz = tk;
        @(posedge clk); #3;
        bus_sel = 0; bus_wr = 0; tick_1hz = 0;
    endtask

    task automatic rd(input logic [5:0] a, input int exp, input string tag);
        @(posedge clk); #3;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(posedge clk); #1;
        chk(tag, int'(bus_rdata), exp);
        #2 bus_sel = 0;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #3 tick_1hz = 1;
            @(posedge clk); #3 tick_1hz = 0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic chk_irq(input int exp, input string tag);
        @(posedge clk); #1;
        chk(tag, int'(irq_out), exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #3 rst_n = 1;
        // R1 reset state
        for (int a = 0; a < 10; a++) rd(6'(a * 4), 0, "R1 reset value");
        chk_irq(0, "R1 irq after reset");

        // R2 field layout
        wr(6'h00, 16'hE5FF); rd(6'h00, 16'h053F, "R2 hour/minute fields");
        wr(6'h04, 16'hFFFA); rd(6'h04, 16'h003A, "R2 seconds field");
        wr(6'h20, 16'h1234); rd(6'h20, 16'h1234, "R2 day register");
        wr(6'h1C, 16'hBEEF); rd(6'h1C, 16'hBEEF, "R2 stopwatch placeholder");
        rd(6'h2C, 0, "R2 unmapped offset");

        // R3 ticks ignored while stopped
        tk(3); idle(2); rd(6'h04, 16'h003A, "R3 no count while disabled");
        wr(6'h10, 16'h0080); rd(6'h10, 16'h0080, "R3 run bit readback");

        // R3/R7 counting and second flag
        tk(1); idle(2);
        rd(6'h04, 59, "R3 seconds advanced");
        rd(6'h14, 16'h0010, "R7 second flag");
        tk(1); idle(2);
        rd(6'h00, 16'h0600, "R4 minute and hour carry");
        rd(6'h04, 0, "R4 seconds wrap");
        wr(6'h14, 16'h0010); rd(6'h14, 0, "R9 clear second flag");

        // R5 day wrap
        wr(6'h00, 16'h173B); wr(6'h04, 16'd59); wr(6'h20, 16'hFFFF);
        tk(1); idle(2);
        rd(6'h20, 0, "R5 day wraps");
        rd(6'h00, 0, "R4 hour wraps");
        wr(6'h14, 16'h0014);

        // R8/R10 alarm
        wr(6'h08, 16'h0000); wr(6'h0C, 16'd2); wr(6'h24, 16'h0000);
        wr(6'h18, 16'h0004);
        tk(1); idle(2);
        rd(6'h14, 16'h0010, "R8 no alarm before match");
        chk_irq(0, "R10 unmasked flag only");
        tk(1); idle(2);
        rd(6'h14, 16'h0014, "R8 alarm on match");
        chk_irq(1, "R10 irq on enabled alarm");
        wr(6'h14, 16'h0000); rd(6'h14, 16'h0014, "R9 zero write keeps flags");
        wr(6'h14, 16'h0014); rd(6'h14, 0, "R9 write-back clears");
        chk_irq(0, "R10 irq drops");

        // R8 load equal to alarm sets nothing
        wr(6'h04, 16'd2); idle(3);
        rd(6'h14, 0, "R8 load does not match");

        // R6 write beats tick
        wr(6'h04, 16'd40, 1'b1); idle(3);
        rd(6'h04, 40, "R6 write wins over tick");
        rd(6'h14, 0, "R6 discarded tick has no event");

        // R11 set beats clear
        @(posedge clk); #3 tick_1hz = 1;
        @(posedge clk); #3 tick_1hz = 0;
        bus_sel = 1; bus_wr = 1; bus_addr = 6'h14; bus_wdata = 16'h0010;
        @(posedge clk); #3 bus_sel = 0; bus_wr = 0;
        rd(6'h14, 16'h0010, "R11 set wins over clear");

        // burst of back-to-back ticks, then stop mid-burst
        wr(6'h18, 16'h0015); rd(6'h18, 16'h0015, "R10 enable readback");
        @(posedge clk); #3 tick_1hz = 1;
        idle(130);
        #3 bus_sel = 1; bus_wr = 1; bus_addr = 6'h10; bus_wdata = 16'h0000;
        @(posedge clk); #3 bus_sel = 0; bus_wr = 0;
        idle(10);
        #3 tick_1hz = 0;
        rd(6'h04, mread(6'h04), "R3 burst and stop");
        rd(6'h00, mread(6'h00), "R4 burst carry");

        idle(3);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule